// File: doc/BRIEF.md
# Out-of-Order Issue Scoreboard

This block is the central hazard controller for a set of floating-point functional units. A decoder presents one instruction per cycle: an operation (load, add, subtract, multiply or divide), a destination register and two source registers. Instructions enter in program order. Each one then waits on its own for its operands, runs for a fixed number of cycles and writes its result. So a later instruction may read, execute and complete before an earlier one.

The block keeps three tables. A per-unit status entry records the operation, the destination, both sources, the unit producing each source and a ready flag for each source. A per-register table names the unit that will write each register, with code 0 meaning no pending writer. The issue, read, execute and write progress of each instruction is kept in the per-unit stage.

There are five units, each with a 3-bit code: an integer/load unit (code 1), two multipliers (codes 2 and 3), an adder for add and subtract (code 4) and a divider (code 5). Bit i of every per-unit vector belongs to the unit with code i+1. The arithmetic itself is modelled as countdown timers. The block shows, through its outputs, when each unit is granted its operand read and its register write.

Top module: `fp_scoreboard`

## Requirements
- R1: `issue_ok` is high in a cycle exactly when `in_valid` is high, reset is released, the unit chosen for the operation is idle, and no unit still owes a write to `in_dst`. While `issue_ok` is low the instruction is not taken, and it stays on the inputs until it is accepted.
- R2: The operation codes on `in_op` are 0 load, 1 add, 2 subtract, 3 multiply and 4 divide. A load goes to code 1. Add and subtract go to code 4 and divide goes to code 5. A multiply goes to code 2 if that unit is idle, and otherwise to code 3. An accepted instruction makes its unit busy from the next cycle.
- R3: A busy unit pulses `fu_read` for exactly one cycle. This happens in the first cycle after issue in which neither of its sources has a pending producer.
- R4: When a producer writes a register in cycle t, a unit waiting on that register may read it in cycle t+1 and no earlier. This includes an instruction issued in cycle t itself.
- R5: A unit that reads in cycle r becomes eligible to write in cycle r+1+L. L is 1 for load, 2 for add and subtract, 10 for multiply and 40 for divide.
- R6: An eligible unit does not write while another busy unit has not yet read a source register equal to its destination, where that source was ready without a producer.
- R7: At most one `fu_write` bit is high per cycle. Among the units eligible and free of the hazard in R6, the lowest code writes.
- R8: In a write cycle, `wb_valid` is high, `wb_unit` gives the writer's code and `wb_reg` gives its destination. The unit is idle in the next cycle, and its destination may be claimed again from that cycle.
- R9: While reset is held low, `issue_ok`, `fu_busy`, `fu_read` and `fu_write` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 3 | Operation code (see R2) |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| issue_ok | output | 1 | Instruction accepted this cycle |
| fu_busy | output | 5 | Per-unit busy flags |
| fu_read | output | 5 | Per-unit operand-read pulse |
| fu_write | output | 5 | Per-unit write grant |
| wb_valid | output | 1 | A write happens this cycle |
| wb_unit | output | 3 | Code of the writing unit |
| wb_reg | output | 5 | Register being written |

## Verification
Some properties are checked on every cycle:
- at most one write grant per cycle;
- a unit becomes idle right after its write;
- each read pulse lasts a single cycle;
- an accepted destination is marked as pending;
- the busy count rises by one on an issue with no write in that cycle;
- no write is granted while another busy unit still waits, with its ready flag set, to read the register being written.

Other behaviour can only be shown by the bench, which replays a model of the tables against the ports. This covers:
- exact read and write cycles after long latencies;
- lowest-code priority when two units finish together;
- the one-cycle gap between a write and a dependent read;
- a divide blocking an earlier-finished add through a register it has not read;
- the second multiplier taking an instruction when the first is busy.

// File: rtl/sb_pkg.sv
// Shared types and unit numbering for the scoreboard.
// Assumes five functional units with fixed roles; index i has code i+1.
package sb_pkg;
    localparam int NUM_FU  = 5;
    localparam int CODE_W  = 3;
    localparam int FU_INT  = 0;
    localparam int FU_MUL0 = 1;
    localparam int FU_MUL1 = 2;
    localparam int FU_ADD  = 3;
    localparam int FU_DIV  = 4;

    typedef enum logic [2:0] {
        OP_LOAD = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_MUL  = 3'd3,
        OP_DIV  = 3'd4
    } sb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } sb_stage_e;
endpackage

// File: rtl/sb_fu_entry.sv
// One functional-unit status entry with its countdown model.
// It holds the operation, the destination, both sources, the producer codes
// and the ready flags. It waits for both operands, counts the latency of its
// operation, then holds in DONE until it is granted the write.
// Assumes issue_en only arrives while the entry is idle.
module sb_fu_entry
    import sb_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int LAT_W    = 6,
    parameter int LAT_LOAD = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_en,
    input  sb_op_e            issue_op,
    input  logic [REG_W-1:0]  issue_fi,
    input  logic [REG_W-1:0]  issue_fj,
    input  logic [REG_W-1:0]  issue_fk,
    input  logic [CODE_W-1:0] issue_qj,
    input  logic [CODE_W-1:0] issue_qk,
    input  logic [CODE_W-1:0] wake_code,
    input  logic              wr_grant,
    output logic              busy,
    output logic [REG_W-1:0]  fi,
    output logic [REG_W-1:0]  fj,
    output logic [REG_W-1:0]  fk,
    output logic              rj,
    output logic              rk,
    output logic              rd_fire,
    output logic              done
);
    sb_stage_e         stage;
    sb_op_e            op;
    logic [CODE_W-1:0] qj, qk;
    logic [LAT_W-1:0]  cnt;

    // Latency minus one, loaded into the countdown at the operand read.
    function automatic logic [LAT_W-1:0] lat_m1(input sb_op_e o);
        case (o)
            OP_LOAD:        return LAT_W'(LAT_LOAD - 1);
            OP_ADD, OP_SUB: return LAT_W'(LAT_ADD - 1);
            OP_MUL:         return LAT_W'(LAT_MUL - 1);
            default:        return LAT_W'(LAT_DIV - 1);
        endcase
    endfunction

    assign busy    = (stage != ST_IDLE);
    assign rd_fire = (stage == ST_WAIT) && rj && rk;
    assign done    = (stage == ST_DONE);

    // Stage, field and ready-flag updates for this unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= ST_IDLE;
            op    <= OP_LOAD;
            fi    <= '0;
            fj    <= '0;
            fk    <= '0;
            qj    <= '0;
            qk    <= '0;
            rj    <= 1'b0;
            rk    <= 1'b0;
            cnt   <= '0;
        end else if (issue_en) begin
            stage <= ST_WAIT;
            op    <= issue_op;
            fi    <= issue_fi;
            fj    <= issue_fj;
            fk    <= issue_fk;
            qj    <= issue_qj;
            qk    <= issue_qk;
            rj    <= (issue_qj == '0);
            rk    <= (issue_qk == '0);
        end else begin
            case (stage)
                ST_WAIT: begin
                    if (rd_fire) begin
                        rj    <= 1'b0;
                        rk    <= 1'b0;
                        cnt   <= lat_m1(op);
                        stage <= ST_EXEC;
                    end else begin
                        if (wake_code != '0 && qj == wake_code) begin
                            rj <= 1'b1;
                            qj <= '0;
                        end
                        if (wake_code != '0 && qk == wake_code) begin
                            rk <= 1'b1;
                            qk <= '0;
                        end
                    end
                end
                ST_EXEC: begin
                    if (cnt == '0) stage <= ST_DONE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_DONE: begin
                    if (wr_grant) stage <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sb_issue_select.sv
// Picks the unit for the presented operation and decides whether it issues.
// Multiply prefers the first multiplier. Unknown operation codes never issue.
// Assumes dst_pending is already the register-table lookup for in_dst.
module sb_issue_select
    import sb_pkg::*;
(
    input  logic              in_valid,
    input  logic              rst_n,
    input  sb_op_e            op,
    input  logic              dst_pending,
    input  logic [NUM_FU-1:0] busy,
    output logic              issue_ok,
    output logic [NUM_FU-1:0] issue_vec
);
    logic [NUM_FU-1:0] pick;

    // Map the operation to a free unit, if there is one.
    always_comb begin
        pick = '0;
        case (op)
            OP_LOAD:        pick[FU_INT] = !busy[FU_INT];
            OP_ADD, OP_SUB: pick[FU_ADD] = !busy[FU_ADD];
            OP_MUL: begin
                if (!busy[FU_MUL0]) pick[FU_MUL0] = 1'b1;
                else                pick[FU_MUL1] = !busy[FU_MUL1];
            end
            OP_DIV:         pick[FU_DIV] = !busy[FU_DIV];
            default: ;
        endcase
    end

    assign issue_ok  = rst_n && in_valid && (|pick) && !dst_pending;
    assign issue_vec = issue_ok ? pick : '0;
endmodule

// File: rtl/sb_wb_arbiter.sv
// Grants the single register write of a cycle.
// A finished unit is blocked while another busy unit still holds a ready,
// unread source equal to its destination. The lowest index wins among the rest.
module sb_wb_arbiter #(
    parameter int N     = 5,
    parameter int REG_W = 5
) (
    input  logic [N-1:0]            done,
    input  logic [N-1:0]            busy,
    input  logic [N-1:0][REG_W-1:0] fi,
    input  logic [N-1:0][REG_W-1:0] fj,
    input  logic [N-1:0][REG_W-1:0] fk,
    input  logic [N-1:0]            rj,
    input  logic [N-1:0]            rk,
    output logic [N-1:0]            grant
);
    logic [N-1:0] eligible;

    for (genvar u = 0; u < N; u++) begin : g_war
        logic hit;
        // Search every other unit for an unread use of this destination.
        always_comb begin
            hit = 1'b0;
            for (int f = 0; f < N; f++) begin
                if (f != u && busy[f] &&
                    ((fj[f] == fi[u] && rj[f]) || (fk[f] == fi[u] && rk[f])))
                    hit = 1'b1;
            end
        end
        assign eligible[u] = done[u] & ~hit;
    end

    // Fixed priority: the lowest eligible index takes the write port.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (eligible[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fp_scoreboard.sv
// Scoreboard top. Holds the register result table, the unit entries, the
// issue selector and the write arbiter.
// Issue is in order. Read, execute and write run out of order per unit.
// A source whose producer writes in the cycle of issue is taken as ready.
module fp_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int LAT_LOAD = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [2:0]   in_op,
    input  logic [4:0]   in_dst,
    input  logic [4:0]   in_src1,
    input  logic [4:0]   in_src2,
    output logic         issue_ok,
    output logic [4:0]   fu_busy,
    output logic [4:0]   fu_read,
    output logic [4:0]   fu_write,
    output logic         wb_valid,
    output logic [2:0]   wb_unit,
    output logic [4:0]   wb_reg
);
    localparam int REG_W   = $clog2(NUM_REGS);
    localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ? LAT_DIV : LAT_MUL;
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

    sb_op_e                         op_e;
    logic [CODE_W-1:0]              res_unit [NUM_REGS];
    logic [NUM_REGS-1:0]            reg_pending;
    logic [NUM_FU-1:0]              issue_vec;
    logic [NUM_FU-1:0]              done_vec, rj_vec, rk_vec;
    logic [NUM_FU-1:0][REG_W-1:0]   fi_all, fj_all, fk_all;
    logic [CODE_W-1:0]              q1, q2, issue_code, wake_code;

    assign op_e = sb_op_e'(in_op);

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
        assign reg_pending[r] = (res_unit[r] != '0);
    end

    sb_issue_select u_issue (
        .in_valid    (in_valid),
        .rst_n       (rst_n),
        .op          (op_e),
        .dst_pending (reg_pending[in_dst]),
        .busy        (fu_busy),
        .issue_ok    (issue_ok),
        .issue_vec   (issue_vec)
    );

    // Write-port view: the code and register of the granted unit.
    always_comb begin
        wb_reg     = '0;
        wb_unit    = '0;
        issue_code = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (fu_write[i]) begin
                wb_reg  = fi_all[i];
                wb_unit = CODE_W'(i + 1);
            end
            if (issue_vec[i]) issue_code = CODE_W'(i + 1);
        end
    end
    assign wb_valid  = |fu_write;
    assign wake_code = wb_valid ? wb_unit : '0;

    // Producer lookup for the sources, bypassing a same-cycle write.
    always_comb begin
        q1 = res_unit[in_src1];
        q2 = res_unit[in_src2];
        if (wb_valid && q1 == wb_unit) q1 = '0;
        if (wb_valid && q2 == wb_unit) q2 = '0;
    end

    // Register result table: cleared on write, claimed on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) res_unit[r] <= '0;
        end else begin
            if (wb_valid) res_unit[wb_reg] <= '0;
            if (issue_ok) res_unit[in_dst] <= issue_code;
        end
    end

    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
        sb_fu_entry #(
            .REG_W    (REG_W),
            .LAT_W    (LAT_W),
            .LAT_LOAD (LAT_LOAD),
            .LAT_ADD  (LAT_ADD),
            .LAT_MUL  (LAT_MUL),
            .LAT_DIV  (LAT_DIV)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_en  (issue_vec[g]),
            .issue_op  (op_e),
            .issue_fi  (in_dst),
            .issue_fj  (in_src1),
            .issue_fk  (in_src2),
            .issue_qj  (q1),
            .issue_qk  (q2),
            .wake_code (wake_code),
            .wr_grant  (fu_write[g]),
            .busy      (fu_busy[g]),
            .fi        (fi_all[g]),
            .fj        (fj_all[g]),
            .fk        (fk_all[g]),
            .rj        (rj_vec[g]),
            .rk        (rk_vec[g]),
            .rd_fire   (fu_read[g]),
            .done      (done_vec[g])
        );
    end

    sb_wb_arbiter #(.N(NUM_FU), .REG_W(REG_W)) u_arb (
        .done  (done_vec),
        .busy  (fu_busy),
        .fi    (fi_all),
        .fj    (fj_all),
        .fk    (fk_all),
        .rj    (rj_vec),
        .rk    (rk_vec),
        .grant (fu_write)
    );
endmodule

// File: rtl/sb_checker.sv
// Cycle-by-cycle properties of the scoreboard, attached to the top by bind.
// Assumes unit index i carries code i+1, as in the package.
module sb_checker #(
    parameter int NUM_FU   = 5,
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          issue_ok,
    input logic [REG_W-1:0]              in_dst,
    input logic [NUM_FU-1:0]             fu_busy,
    input logic [NUM_FU-1:0]             fu_read,
    input logic [NUM_FU-1:0]             fu_write,
    input logic [REG_W-1:0]              wb_reg,
    input logic [NUM_REGS-1:0]           reg_pending,
    input logic [NUM_FU-1:0][REG_W-1:0]  fj_all,
    input logic [NUM_FU-1:0][REG_W-1:0]  fk_all,
    input logic [NUM_FU-1:0]             rj_vec,
    input logic [NUM_FU-1:0]             rk_vec
);
    assert_one_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fu_write));

    assert_claim_dst_R1: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> reg_pending[$past(in_dst)]);

    assert_busy_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_ok && !(|fu_write)) |=>
            ($countones(fu_busy) == $countones($past(fu_busy)) + 1));

    for (genvar i = 0; i < NUM_FU; i++) begin : g_unit
        assert_write_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fu_write[i] |=> !fu_busy[i]);

        assert_read_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fu_read[i] |=> !fu_read[i]);

        for (genvar f = 0; f < NUM_FU; f++) begin : g_other
            if (f != i) begin : g_pair
                assert_no_war_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    (fu_write[i] && fu_busy[f]) |->
                        !((rj_vec[f] && fj_all[f] == wb_reg) ||
                          (rk_vec[f] && fk_all[f] == wb_reg)));
            end
        end
    end
endmodule

bind fp_scoreboard sb_checker #(.NUM_REGS(NUM_REGS)) u_sb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ok    (issue_ok),
    .in_dst      (in_dst),
    .fu_busy     (fu_busy),
    .fu_read     (fu_read),
    .fu_write    (fu_write),
    .wb_reg      (wb_reg),
    .reg_pending (reg_pending),
    .fj_all      (fj_all),
    .fk_all      (fk_all),
    .rj_vec      (rj_vec),
    .rk_vec      (rk_vec)
);

// File: tb/fp_scoreboard_bench.sv
// Bench for the scoreboard.
// A negedge monitor replays the tables from the requirements and predicts
// issue, read and write every cycle. Directed scenarios check chosen timings.
module fp_scoreboard_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic       issue_ok, wb_valid;
    logic [4:0] fu_busy, fu_read, fu_write, wb_reg;
    logic [2:0] wb_unit;

    int total = 0, bad = 0, cyc = 0;
    bit done_flag = 0;

    // Model state
    bit busy_m[5], read_m[5];
    int dst_m[5], s1_m[5], s2_m[5], p1_m[5], p2_m[5], lat_m[5];
    int rd_cyc[5], wr_cyc[5], iss_cyc[5];
    int owner_m[32];

    always #5 clk = ~clk;

    fp_scoreboard u_fp_scoreboard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .issue_ok(issue_ok), .fu_busy(fu_busy), .fu_read(fu_read),
        .fu_write(fu_write), .wb_valid(wb_valid), .wb_unit(wb_unit), .wb_reg(wb_reg)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int pick_unit(input logic [2:0] op);
        case (op)
            3'd0:       return busy_m[0] ? -1 : 0;
            3'd1, 3'd2: return busy_m[3] ? -1 : 3;
            3'd3:       return !busy_m[1] ? 1 : (!busy_m[2] ? 2 : -1);
            3'd4:       return busy_m[4] ? -1 : 4;
            default:    return -1;
        endcase
    endfunction

    function automatic int lat_of(input logic [2:0] op);
        case (op)
            3'd0:       return 1;
            3'd1, 3'd2: return 2;
            3'd3:       return 10;
            default:    return 40;
        endcase
    endfunction

    function automatic bit war_blocked(input int u);
        for (int v = 0; v < 5; v++)
            if (v != u && busy_m[v] && !read_m[v] &&
                ((s1_m[v] == dst_m[u] && p1_m[v] == 0) ||
                 (s2_m[v] == dst_m[u] && p2_m[v] == 0)))
                return 1;
        return 0;
    endfunction

    // Model replay and per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            logic [4:0] exp_rd, exp_wr, busy_vec;
            int eu, wu;
            bit eok;
            cyc++;
            busy_vec = '0;
            for (int u = 0; u < 5; u++) busy_vec[u] = busy_m[u];
            chk(fu_busy == busy_vec, "R2 busy map", fu_busy, busy_vec);
            eu  = pick_unit(in_op);
            eok = in_valid && eu >= 0 && owner_m[in_dst] == 0;
            chk(issue_ok == eok, "R1 issue", issue_ok, eok);
            exp_rd = '0;
            for (int u = 0; u < 5; u++)
                if (busy_m[u] && !read_m[u] && p1_m[u] == 0 && p2_m[u] == 0) exp_rd[u] = 1'b1;
            chk(fu_read == exp_rd, "R3 R4 read", fu_read, exp_rd);
            exp_wr = '0;
            wu = -1;
            for (int u = 0; u < 5; u++)
                if (wu < 0 && busy_m[u] && read_m[u] && cyc >= rd_cyc[u] + lat_m[u] + 1 && !war_blocked(u)) begin
                    exp_wr[u] = 1'b1;
                    wu = u;
                end
            chk(fu_write == exp_wr, "R5 R6 R7 write", fu_write, exp_wr);
            if (wu >= 0) begin
                chk(wb_valid && wb_unit == 3'(wu + 1), "R8 wb_unit", wb_unit, wu + 1);
                chk(wb_reg == 5'(dst_m[wu]), "R8 wb_reg", wb_reg, dst_m[wu]);
                busy_m[wu] = 0;
                owner_m[dst_m[wu]] = 0;
                wr_cyc[wu] = cyc;
                for (int v = 0; v < 5; v++) begin
                    if (p1_m[v] == wu + 1) p1_m[v] = 0;
                    if (p2_m[v] == wu + 1) p2_m[v] = 0;
                end
            end
            for (int u = 0; u < 5; u++)
                if (exp_rd[u]) begin
                    read_m[u] = 1;
                    rd_cyc[u] = cyc;
                end
            if (eok) begin
                busy_m[eu]  = 1;
                read_m[eu]  = 0;
                dst_m[eu]   = in_dst;
                s1_m[eu]    = in_src1;
                s2_m[eu]    = in_src2;
                p1_m[eu]    = owner_m[in_src1];
                p2_m[eu]    = owner_m[in_src2];
                lat_m[eu]   = lat_of(in_op);
                iss_cyc[eu] = cyc;
                owner_m[in_dst] = eu + 1;
            end
        end
    end

    // Presents one instruction from just after an edge until it is accepted.
    task automatic issue(input logic [2:0] op, input int d, input int a, input int b);
        in_valid = 1'b1;
        in_op = op;
        in_dst = 5'(d);
        in_src1 = 5'(a);
        in_src2 = 5'(b);
        do @(negedge clk); while (!issue_ok);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin @(posedge clk); #1; end while (fu_busy != 0);
        repeat (2) begin @(posedge clk); #1; end
    endtask

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int r = 0; r < 32; r++) owner_m[r] = 0;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state with a valid instruction waiting
        chk(issue_ok == 1'b0, "R9 issue in reset", issue_ok, 0);
        chk(fu_busy == 0 && fu_read == 0 && fu_write == 0, "R9 idle in reset", fu_busy, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R5: lone add writes four cycles after issue
        issue(3'd1, 1, 2, 3);
        wait_idle();
        chk(wr_cyc[3] == iss_cyc[3] + 4, "R5 add timing", wr_cyc[3] - iss_cyc[3], 4);

        // R1: add to a register a multiply still owns waits for that write
        issue(3'd3, 4, 2, 3);
        issue(3'd1, 4, 5, 6);
        wait_idle();
        chk(iss_cyc[3] == wr_cyc[1] + 1, "R1 WAW stall", iss_cyc[3], wr_cyc[1] + 1);

        // R4: dependent add reads one cycle after the load writes
        issue(3'd0, 7, 1, 1);
        issue(3'd1, 8, 7, 7);
        wait_idle();
        chk(rd_cyc[3] == wr_cyc[0] + 1, "R4 RAW wake", rd_cyc[3], wr_cyc[0] + 1);

        // R6: add to a register an older divide has not read is held
        issue(3'd3, 0, 2, 4);
        issue(3'd4, 10, 0, 6);
        issue(3'd1, 6, 8, 8);
        wait_idle();
        chk(wr_cyc[3] == rd_cyc[4] + 1, "R6 WAR hold", wr_cyc[3], rd_cyc[4] + 1);
        chk(wr_cyc[3] > iss_cyc[3] + 4, "R6 add delayed", wr_cyc[3] - iss_cyc[3], 5);

        // R7: load and add finishing together, lower code first
        issue(3'd1, 11, 12, 13);
        issue(3'd0, 14, 15, 15);
        wait_idle();
        chk(wr_cyc[0] == iss_cyc[0] + 3, "R7 load first", wr_cyc[0] - iss_cyc[0], 3);
        chk(wr_cyc[3] == wr_cyc[0] + 1, "R7 add next", wr_cyc[3], wr_cyc[0] + 1);

        // R2: second multiply goes to the second multiplier
        issue(3'd3, 16, 1, 2);
        issue(3'd3, 17, 1, 2);
        chk(fu_busy[2:1] == 2'b11, "R2 two multipliers", fu_busy[2:1], 3);
        wait_idle();
        chk(wr_cyc[2] == wr_cyc[1] + 1, "R7 mul order", wr_cyc[2], wr_cyc[1] + 1);

        // Random stream over a small register set for frequent hazards
        for (int n = 0; n < 250; n++) begin
            int gap;
            issue(3'($urandom % 5), $urandom % 8, $urandom % 8, $urandom % 8);
            gap = $urandom % 3;
            repeat (gap) begin @(posedge clk); #1; end
        end
        wait_idle();
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done_flag = 1;
        bad++;
        total++;
        $display("FAIL R1 watchdog expired actual=%0d expected=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule